// File: doc/BRIEF.md
# Activity Monitor Counter Control

This block holds the global control word for a bank of activity-monitor event counters. The counters are split into an architected group and an auxiliary group. Each counter is 64 bits wide and counts up by one on every clock cycle in which its event input is high. The control word has two live bits. One freezes every counter while the core sits halted in debug state. The other hides auxiliary counter values from low-privilege system-register reads.

Software writes the control word through a port tagged with the issuing privilege level. Only the highest implemented level may change it. Any other write is refused and flagged as undefined in the same cycle. Counter values leave the block through two read ports, each selecting by group and index. The system-register view applies the privilege-based zeroing. The memory-mapped view always shows the true counts.

Top module: `amc_ctrl_top`

## Requirements
- R1: While reset is low and after its release, the control word and every counter read as zero.
- R2: Only bit 10 (halt-in-debug) and bit 17 (auxiliary read-zero) of the 64-bit control word can hold a 1; every other bit always reads zero whatever is written.
- R3: A write with privilege level equal to 3 (the highest, 2-bit level encoding) loads the control word at the next clock edge. A write at any other level raises `wr_undef_o` in the same cycle and leaves the control word unchanged.
- R4: A counter's value rises by exactly one for each clock edge at which its event input is high and counting is not frozen. The new value is visible on the read ports right after that edge. Group select 0 picks the architected group and 1 picks the auxiliary group.
- R5: When bit 10 is 1 and `dbg_halt_i` is high at an edge, no counter in either group changes. When bit 10 is 0, counting continues through debug halt.
- R6: A write that changes bit 10 governs counting from the first edge after the one that loads it.
- R7: When bit 17 is 1, a system-view read of an auxiliary counter returns zero unless `sys_el_i` equals 3, in which case it returns the true count.
- R8: When bit 17 is 0, system-view reads of auxiliary counters return the true count at every privilege level.
- R9: Architected-group system reads and all memory-mapped reads return the true count regardless of bit 17.
- R10: With the extended revision parameter cleared, bit 17 reads zero and cannot be set, and auxiliary reads are never zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control word write strobe |
| wr_el_i | input | 2 | Privilege level of the write |
| wr_data_i | input | 64 | Write data |
| wr_undef_o | output | 1 | Write refused (issued below the highest level) |
| ctrl_o | output | 64 | Current control word |
| dbg_halt_i | input | 1 | Core halted in debug state |
| evt_arch_i | input | N_ARCH | Event pulses, architected group |
| evt_aux_i | input | N_AUX | Event pulses, auxiliary group |
| sys_grp_i | input | 1 | System view group select |
| sys_idx_i | input | IDX_W | System view counter index |
| sys_el_i | input | 2 | Privilege level of the system read |
| sys_data_o | output | 64 | System view read data |
| mm_grp_i | input | 1 | Memory-mapped view group select |
| mm_idx_i | input | IDX_W | Memory-mapped view counter index |
| mm_data_o | output | 64 | Memory-mapped view read data |

## Verification
`wr_undef_o` and both read ports are combinational, so they are due in the same cycle as the select, level and write inputs that drive them. A control write or an event shows up one edge later. A change to bit 10 alters counting only two edges after the write is presented. The bench changes inputs on the falling edge and compares every output shortly after, against a model that advances once per cycle with the values seen at the rising edge. Each of these latencies is therefore checked in its own cycle, never a cycle early or late.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam int unsigned CTRL_W  = 64;
  localparam int unsigned HALT_B  = 10;
  localparam int unsigned RZ_B    = 17;
  localparam int unsigned PRIV_W  = 2;

  typedef logic [PRIV_W-1:0] priv_t;
  typedef logic [CTRL_W-1:0] ctrl_t;

  typedef enum logic {
    GRP_ARCH = 1'b0,
    GRP_AUX  = 1'b1
  } grp_e;

  function automatic ctrl_t ctrl_keep(input bit has_rz);
    ctrl_t m;
    m = '0;
    m[HALT_B] = 1'b1;
    m[RZ_B]   = has_rz;
    return m;
  endfunction
endpackage

// File: rtl/amc_ctrl_reg.sv
module amc_ctrl_reg
  import amc_pkg::*;
#(
  parameter int unsigned TOP_EL = 3,
  parameter bit          HAS_RZ = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  priv_t wr_el_i,
  input  ctrl_t wr_data_i,
  output ctrl_t ctrl_o,
  output logic  halt_en_o,
  output logic  rz_en_o,
  output logic  wr_undef_o
);
  localparam ctrl_t KEEP = ctrl_keep(HAS_RZ);

  logic  wr_ok;
  ctrl_t ctrl_q;

  assign wr_ok      = wr_en_i && (wr_el_i == priv_t'(TOP_EL));
  assign wr_undef_o = wr_en_i && !wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_q <= '0;
    else if (wr_ok) ctrl_q <= wr_data_i & KEEP;
  end

  assign ctrl_o    = ctrl_q;
  assign halt_en_o = ctrl_q[HALT_B];

  generate
    if (HAS_RZ) begin : g_rz
      assign rz_en_o = ctrl_q[RZ_B];
    end else begin : g_no_rz
      assign rz_en_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/amc_cnt_bank.sv
module amc_cnt_bank #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              evt_i,
  input  logic                      freeze_i,
  output logic [N-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (evt_i[g] && !freeze_i) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g] = cnt_q;
  end
endmodule

// File: rtl/amc_rd_port.sv
module amc_rd_port
  import amc_pkg::*;
#(
  parameter int unsigned N_ARCH  = 4,
  parameter int unsigned N_AUX   = 4,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned IDX_W   = 2,
  parameter bit          MASK_EN = 1'b1,
  parameter int unsigned TOP_EL  = 3
) (
  input  logic [N_ARCH-1:0][CNT_W-1:0] arch_cnt_i,
  input  logic [N_AUX-1:0][CNT_W-1:0]  aux_cnt_i,
  input  logic                         grp_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  priv_t                        el_i,
  input  logic                         rz_en_i,
  output logic [CNT_W-1:0]             data_o
);
  logic [CNT_W-1:0] arch_sel, aux_sel, raw;

  always_comb begin
    arch_sel = '0;
    for (int i = 0; i < int'(N_ARCH); i++)
      if (int'(idx_i) == i) arch_sel = arch_cnt_i[i];
  end

  always_comb begin
    aux_sel = '0;
    for (int i = 0; i < int'(N_AUX); i++)
      if (int'(idx_i) == i) aux_sel = aux_cnt_i[i];
  end

  assign raw = (grp_i == GRP_AUX) ? aux_sel : arch_sel;

  generate
    if (MASK_EN) begin : g_mask
      logic hide;
      assign hide   = (grp_i == GRP_AUX) && rz_en_i && (el_i != priv_t'(TOP_EL));
      assign data_o = hide ? '0 : raw;
    end else begin : g_plain
      logic unused_ok;
      assign unused_ok = ^{el_i, rz_en_i};
      assign data_o    = raw;
    end
  endgenerate
endmodule

// File: rtl/amc_ctrl_top.sv
module amc_ctrl_top
  import amc_pkg::*;
#(
  parameter int unsigned N_ARCH = 4,
  parameter int unsigned N_AUX  = 4,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned TOP_EL = 3,
  parameter bit          HAS_RZ = 1'b1,
  localparam int unsigned MAX_N = (N_ARCH > N_AUX) ? N_ARCH : N_AUX,
  localparam int unsigned IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_el_i,
  input  logic [63:0]       wr_data_i,
  output logic              wr_undef_o,
  output logic [63:0]       ctrl_o,
  input  logic              dbg_halt_i,
  input  logic [N_ARCH-1:0] evt_arch_i,
  input  logic [N_AUX-1:0]  evt_aux_i,
  input  logic              sys_grp_i,
  input  logic [IDX_W-1:0]  sys_idx_i,
  input  logic [1:0]        sys_el_i,
  output logic [CNT_W-1:0]  sys_data_o,
  input  logic              mm_grp_i,
  input  logic [IDX_W-1:0]  mm_idx_i,
  output logic [CNT_W-1:0]  mm_data_o
);
  logic halt_en, rz_en, freeze;
  logic [N_ARCH-1:0][CNT_W-1:0] arch_cnt;
  logic [N_AUX-1:0][CNT_W-1:0]  aux_cnt;

  amc_ctrl_reg #(.TOP_EL(TOP_EL), .HAS_RZ(HAS_RZ)) i_ctrl_reg (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_el_i, .wr_data_i,
    .ctrl_o, .halt_en_o(halt_en), .rz_en_o(rz_en), .wr_undef_o
  );

  // control takes effect one edge after it is loaded
  assign freeze = halt_en && dbg_halt_i;

  amc_cnt_bank #(.N(N_ARCH), .CNT_W(CNT_W)) i_bank_arch (
    .clk_i, .rst_ni, .evt_i(evt_arch_i), .freeze_i(freeze), .cnt_o(arch_cnt)
  );

  amc_cnt_bank #(.N(N_AUX), .CNT_W(CNT_W)) i_bank_aux (
    .clk_i, .rst_ni, .evt_i(evt_aux_i), .freeze_i(freeze), .cnt_o(aux_cnt)
  );

  amc_rd_port #(
    .N_ARCH(N_ARCH), .N_AUX(N_AUX), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .MASK_EN(1'b1), .TOP_EL(TOP_EL)
  ) i_rd_sys (
    .arch_cnt_i(arch_cnt), .aux_cnt_i(aux_cnt),
    .grp_i(sys_grp_i), .idx_i(sys_idx_i), .el_i(sys_el_i),
    .rz_en_i(rz_en), .data_o(sys_data_o)
  );

  amc_rd_port #(
    .N_ARCH(N_ARCH), .N_AUX(N_AUX), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .MASK_EN(1'b0), .TOP_EL(TOP_EL)
  ) i_rd_mm (
    .arch_cnt_i(arch_cnt), .aux_cnt_i(aux_cnt),
    .grp_i(mm_grp_i), .idx_i(mm_idx_i), .el_i(2'b00),
    .rz_en_i(1'b0), .data_o(mm_data_o)
  );
endmodule

// File: rtl/amc_ctrl_chk.sv
module amc_ctrl_chk
  import amc_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned TOP_EL = 3,
  parameter bit          HAS_RZ = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_el_i,
  input logic [63:0]       wr_data_i,
  input logic              wr_undef_o,
  input logic [63:0]       ctrl_o,
  input logic              dbg_halt_i,
  input logic              sys_grp_i,
  input logic [IDX_W-1:0]  sys_idx_i,
  input logic [1:0]        sys_el_i,
  input logic [CNT_W-1:0]  sys_data_o,
  input logic              mm_grp_i,
  input logic [IDX_W-1:0]  mm_idx_i,
  input logic [CNT_W-1:0]  mm_data_o
);
  localparam ctrl_t KEEP = ctrl_keep(HAS_RZ);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o & ~KEEP) == '0); // R2

  AST_LOW_WR_UNDEF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_el_i != 2'(TOP_EL)) |-> wr_undef_o); // R3

  AST_LOW_WR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_el_i != 2'(TOP_EL)) |=> $stable(ctrl_o)); // R3

  AST_TOP_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_el_i == 2'(TOP_EL)) |=> (ctrl_o == ($past(wr_data_i) & KEEP))); // R3

  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctrl_o[HALT_B] && dbg_halt_i) && $stable(mm_grp_i) && $stable(mm_idx_i))
      |-> $stable(mm_data_o)); // R5

  AST_RZ_HIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_grp_i && ctrl_o[RZ_B] && sys_el_i != 2'(TOP_EL)) |-> (sys_data_o == '0)); // R7

  AST_VIEWS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_grp_i == mm_grp_i && sys_idx_i == mm_idx_i &&
     (!sys_grp_i || !ctrl_o[RZ_B] || sys_el_i == 2'(TOP_EL)))
      |-> (sys_data_o == mm_data_o)); // R9
endmodule

bind amc_ctrl_top amc_ctrl_chk #(
  .CNT_W(CNT_W), .IDX_W(IDX_W), .TOP_EL(TOP_EL), .HAS_RZ(HAS_RZ)
) i_amc_ctrl_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .wr_el_i(wr_el_i), .wr_data_i(wr_data_i),
  .wr_undef_o(wr_undef_o), .ctrl_o(ctrl_o), .dbg_halt_i(dbg_halt_i),
  .sys_grp_i(sys_grp_i), .sys_idx_i(sys_idx_i), .sys_el_i(sys_el_i),
  .sys_data_o(sys_data_o), .mm_grp_i(mm_grp_i), .mm_idx_i(mm_idx_i),
  .mm_data_o(mm_data_o)
);

// File: tb/test_amc_ctrl_top.sv
module test_amc_ctrl_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_el = '0;
  logic [63:0] wr_data = '0;
  logic        dbg = 1'b0;
  logic [3:0]  evt_a = '0, evt_x = '0;
  logic        s_grp = 1'b0, m_grp = 1'b0;
  logic [1:0]  s_idx = '0, m_idx = '0, s_el = '0;

  logic        undef, undef_n;
  logic [63:0] ctrl, ctrl_n, s_dat, m_dat, s_dat_n, m_dat_n;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  amc_ctrl_top i_amc_ctrl_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_el_i(wr_el), .wr_data_i(wr_data),
    .wr_undef_o(undef), .ctrl_o(ctrl), .dbg_halt_i(dbg),
    .evt_arch_i(evt_a), .evt_aux_i(evt_x),
    .sys_grp_i(s_grp), .sys_idx_i(s_idx), .sys_el_i(s_el), .sys_data_o(s_dat),
    .mm_grp_i(m_grp), .mm_idx_i(m_idx), .mm_data_o(m_dat)
  );

  amc_ctrl_top #(.HAS_RZ(1'b0)) i_amc_ctrl_top_norz (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_el_i(wr_el), .wr_data_i(wr_data),
    .wr_undef_o(undef_n), .ctrl_o(ctrl_n), .dbg_halt_i(dbg),
    .evt_arch_i(evt_a), .evt_aux_i(evt_x),
    .sys_grp_i(s_grp), .sys_idx_i(s_idx), .sys_el_i(s_el), .sys_data_o(s_dat_n),
    .mm_grp_i(m_grp), .mm_idx_i(m_idx), .mm_data_o(m_dat_n)
  );

  // reference state
  longint unsigned arch_m[4], aux_m[4];
  logic [63:0] ctrl_m;
  bit halt_chg_d1, halt_chg_d2;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned pick(input logic g, input logic [1:0] i);
    return g ? aux_m[i] : arch_m[i];
  endfunction

  task automatic compare();
    longint unsigned sv, mv;
    string st;
    sv = pick(s_grp, s_idx);
    mv = pick(m_grp, m_idx);
    if (s_grp && ctrl_m[17] && s_el != 2'd3) begin sv = 0; st = "R7"; end
    else if (s_grp && ctrl_m[17]) st = "R7";
    else if (s_grp) st = "R8";
    else st = "R9";
    chk(st, s_dat, sv);
    if (halt_chg_d2)            chk("R6", m_dat, mv);
    else if (ctrl_m[10] && dbg) chk("R5", m_dat, mv);
    else if (ctrl_m[17])        chk("R9", m_dat, mv);
    else                        chk("R4", m_dat, mv);
    chk("R2", ctrl, ctrl_m);
    chk("R3", {63'd0, undef}, {63'd0, wr_en && wr_el != 2'd3});
    // R10: second instance, no read-zero bit
    chk("R10", ctrl_n, {46'd0, 1'b0, 6'd0, ctrl_m[10], 10'd0});
    chk("R10", s_dat_n, pick(s_grp, s_idx));
  endtask

  task automatic advance();
    bit frz;
    logic [63:0] nxt;
    frz = ctrl_m[10] && dbg;
    for (int i = 0; i < 4; i++) begin
      if (evt_a[i] && !frz) arch_m[i]++;
      if (evt_x[i] && !frz) aux_m[i]++;
    end
    halt_chg_d2 = halt_chg_d1;
    halt_chg_d1 = 0;
    if (wr_en && wr_el == 2'd3) begin
      nxt = 64'd0;
      nxt[10] = wr_data[10];
      nxt[17] = wr_data[17];
      halt_chg_d1 = (nxt[10] != ctrl_m[10]);
      ctrl_m = nxt;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin arch_m[i] = 0; aux_m[i] = 0; end
    ctrl_m = '0;
    halt_chg_d1 = 0;
    halt_chg_d2 = 0;
    // R1: events and a top-level write during reset change nothing
    evt_a = 4'hf; evt_x = 4'hf; wr_en = 1'b1; wr_el = 2'd3; wr_data = '1;
    repeat (3) @(negedge clk);
    chk("R1", ctrl, 64'd0);
    chk("R1", m_dat, 64'd0);
    m_grp = 1'b1;
    #1 chk("R1", m_dat, 64'd0);
    wr_en = 1'b0; evt_a = '0; evt_x = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      evt_a   = 4'($urandom);
      evt_x   = 4'($urandom);
      dbg     = (cyc % 300) > 150 ? (($urandom % 8) != 0) : (($urandom % 8) == 0);
      wr_en   = (($urandom % 7) == 0);
      wr_el   = (($urandom % 3) == 0) ? 2'($urandom) : 2'd3;
      wr_data = {$urandom, $urandom};
      s_grp   = 1'($urandom);
      m_grp   = 1'($urandom);
      s_idx   = 2'($urandom);
      m_idx   = (($urandom % 2) == 0) ? s_idx : 2'($urandom);
      s_el    = 2'($urandom);
      #1;
      compare();
      advance();
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule